// File: doc/BRIEF.md
# Timer Write-Enable Key Guard

This block owns the write-enable bit that protects a set of timer registers. It watches a simple register write bus for two addresses: a key address and a configuration address. Software unlocks the enable bit by writing the first key byte and then the second key byte to the key address. In the single cycle after the second key, a configuration write with the enable bit set is accepted. Outside that cycle, an attempt to set the bit has no effect on it. Clearing the bit is never guarded.

The configuration register is held here as a whole, and its other fields take every configuration write unchanged. The current enable bit gates a timer write request into the write strobe that reaches the timer registers.

Top module: `keyed_wren_guard`

## Requirements
- R1: After reset the configuration value is all zero, the enable output is 0 and the key sequence is idle. A configuration write with bit 13 set in the first cycles after reset leaves the enable at 0.
- R2: A write of low byte 0x55 to the key address, then a write of low byte 0xAA to the key address, opens a window in the next cycle. A configuration write with bit 13 set in that cycle sets the enable, and the enable is visible on the cycle after that write.
- R3: The window lasts exactly one cycle whether or not it is used. A configuration write with bit 13 set one or more cycles later leaves the enable unchanged.
- R4: After the first key, any write other than 0xAA to the key address returns the sequence to idle. A write to any other address also returns it to idle. A key write of 0x55 in any state restarts the sequence at the first-key-seen step.
- R5: Cycles with no bus write between the two keys do not disturb the sequence.
- R6: A configuration write with bit 13 set outside the window leaves the enable unchanged. All other bits of that write are stored into the configuration value.
- R7: A configuration write with bit 13 clear always clears the enable, without any key sequence.
- R8: The timer write strobe equals the timer write request while the enable is 1 and is 0 while the enable is 0, in the same cycle.
- R9: Key comparison uses only bits 7:0 of the write data. Higher data bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Bus write strobe |
| busAddr | input | ADDR_W (8) | Bus write address |
| busWrData | input | DATA_W (16) | Bus write data |
| timerWrReq | input | 1 | Timer register write request |
| timerWrGate | output | 1 | Timer register write strobe, gated by the enable |
| cfgValue | output | DATA_W (16) | Configuration register contents, bit 13 is the enable |
| timerWrEnable | output | 1 | Current enable bit |

## Verification
The unlock state and the configuration register each take one register stage. A key write changes the sequence state at the clock edge that samples it. A configuration write changes `cfgValue` and `timerWrEnable` at its own sampling edge. `timerWrGate` is combinational from the request and the current enable. The bench drives each cycle's inputs on the falling edge and checks the gate before the rising edge. It checks `cfgValue` and the enable on the following falling edge, against a bench model stepped once per rising edge. Directed sequences cover the window edge, broken and restarted keys, and idle gaps. A seeded random stream mixes keys, configuration writes and foreign writes.

// File: rtl/keyed_wren_guard_pkg.sv
package keyed_wren_guard_pkg;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_HALF = 2'd1,
    SEQ_OPEN = 2'd2
  } seqState_t;

  typedef struct packed {
    logic cfgWr;       // configuration write this cycle
    logic setAllowed;  // unlock window is open this cycle
  } cfgStrobe_t;

endpackage

// File: rtl/keyed_wren_seq.sv
module keyed_wren_seq
  import keyed_wren_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h2E,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h3A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        keyByte,
  output cfgStrobe_t        strobe
);

  seqState_t seqState, seqNext;
  logic keyHit, firstKey, secondKey;

  assign keyHit    = busWrEn && (busAddr == KEY_ADDR);
  assign firstKey  = keyHit && (keyByte == KEY_FIRST);
  assign secondKey = keyHit && (keyByte == KEY_SECOND);

  always_comb begin
    seqNext = seqState;
    if (firstKey) begin
      seqNext = SEQ_HALF;
    end else if (seqState == SEQ_HALF) begin
      if (secondKey)    seqNext = SEQ_OPEN;
      else if (busWrEn) seqNext = SEQ_IDLE;
    end else begin
      seqNext = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seqState <= SEQ_IDLE;
    else       seqState <= seqNext;
  end

  assign strobe.cfgWr      = busWrEn && (busAddr == CFG_ADDR);
  assign strobe.setAllowed = (seqState == SEQ_OPEN);

  // R3: the window never stays open two cycles running
  assert_window_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == SEQ_OPEN) |=> (seqState != SEQ_OPEN));

  // R2: the window only opens right after a second-key write
  assert_window_after_key_R2: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == SEQ_OPEN) |-> $past(busWrEn && busAddr == KEY_ADDR && keyByte == KEY_SECOND));

  // R5: an idle cycle keeps the first-key state
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == SEQ_HALF && !busWrEn) |=> (seqState == SEQ_HALF));

endmodule

// File: rtl/keyed_wren_cfg.sv
module keyed_wren_cfg
  import keyed_wren_guard_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EN_BIT = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              timerWrReq,
  output logic              timerWrGate,
  output logic [DATA_W-1:0] cfgValue,
  output logic              timerWrEnable
);

  logic [DATA_W-1:0] cfgReg, cfgNext;
  logic enNext;

  always_comb begin
    enNext = cfgReg[EN_BIT];
    if (!busWrData[EN_BIT])      enNext = 1'b0;
    else if (strobe.setAllowed)  enNext = 1'b1;
    cfgNext = busWrData;
    cfgNext[EN_BIT] = enNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cfgReg <= '0;
    else if (strobe.cfgWr) cfgReg <= cfgNext;
  end

  assign cfgValue      = cfgReg;
  assign timerWrEnable = cfgReg[EN_BIT];
  assign timerWrGate   = timerWrReq && cfgReg[EN_BIT];

  // R2: the enable only rises after a configuration write inside the window
  assert_set_in_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerWrEnable) |-> $past(strobe.cfgWr && strobe.setAllowed));

  // R7: the enable only falls after a configuration write with the bit clear
  assert_clear_by_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(timerWrEnable) |-> $past(strobe.cfgWr && !busWrData[EN_BIT]));

  // R8: no timer write strobe while the enable is clear
  assert_gate_blocked_R8: assert property (@(posedge clk) disable iff (!rstN)
    !timerWrEnable |-> !timerWrGate);

  // R6: configuration writes store every other bit as written
  assert_fields_follow_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cfgWr |=> ((cfgValue ^ $past(busWrData)) & ~(DATA_W'(1) << EN_BIT)) == '0);

endmodule

// File: rtl/keyed_wren_guard.sv
module keyed_wren_guard
  import keyed_wren_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int EN_BIT = 13,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h2E,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h3A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              timerWrReq,
  output logic              timerWrGate,
  output logic [DATA_W-1:0] cfgValue,
  output logic              timerWrEnable
);

  cfgStrobe_t strobe;

  keyed_wren_seq #(
    .ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR), .CFG_ADDR(CFG_ADDR)
  ) u_seq (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .keyByte(busWrData[7:0]), .strobe(strobe)
  );

  keyed_wren_cfg #(
    .DATA_W(DATA_W), .EN_BIT(EN_BIT)
  ) u_cfg (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWrData(busWrData),
    .timerWrReq(timerWrReq), .timerWrGate(timerWrGate),
    .cfgValue(cfgValue), .timerWrEnable(timerWrEnable)
  );

endmodule

// File: tb/keyed_wren_guard_bench.sv
module keyed_wren_guard_bench;

  localparam logic [7:0] KEYA = 8'h2E;
  localparam logic [7:0] CFGA = 8'h3A;
  localparam logic [7:0] OTHA = 8'h40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [7:0] busAddr = '0;
  logic [15:0] busWrData = '0;
  logic timerWrReq = 1'b0;
  logic timerWrGate;
  logic [15:0] cfgValue;
  logic timerWrEnable;

  int compared = 0;
  int mismatched = 0;
  int mState = 0;            // 0 idle, 1 first key seen, 2 window open
  logic [15:0] mCfg = '0;
  bit done = 0;

  always #10 clk = ~clk;     // 50 MHz

  keyed_wren_guard u_keyed_wren_guard (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .timerWrReq(timerWrReq), .timerWrGate(timerWrGate),
    .cfgValue(cfgValue), .timerWrEnable(timerWrEnable)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int nextState(int s, bit we, logic [7:0] a, logic [15:0] d);
    if (we && a == KEYA && d[7:0] == 8'h55) return 1;
    if (s == 1) begin
      if (we && a == KEYA && d[7:0] == 8'hAA) return 2;
      if (we) return 0;
      return 1;
    end
    return 0;
  endfunction

  function automatic logic [15:0] nextCfg(logic [15:0] c, int s, bit we,
                                          logic [7:0] a, logic [15:0] d);
    logic [15:0] n;
    if (!(we && a == CFGA)) return c;
    n = d;
    if (!d[13])      n[13] = 1'b0;
    else if (s == 2) n[13] = 1'b1;
    else             n[13] = c[13];
    return n;
  endfunction

  // one cycle: drive at falling edge, check gate, clock, check registered outputs
  task automatic step(string tag, bit we, logic [7:0] a, logic [15:0] d, bit tw);
    busWrEn = we; busAddr = a; busWrData = d; timerWrReq = tw;
    #1;
    check({tag, " R8 gate"}, {15'd0, timerWrGate}, {15'd0, tw & mCfg[13]});
    @(posedge clk);
    mCfg   = nextCfg(mCfg, mState, we, a, d);
    mState = nextState(mState, we, a, d);
    @(negedge clk);
    check({tag, " cfg"}, cfgValue, mCfg);
    check({tag, " enable"}, {15'd0, timerWrEnable}, {15'd0, mCfg[13]});
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, OTHA, 16'h0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd20240);
    repeat (3) @(negedge clk);
    check("R1 reset cfg", cfgValue, 16'h0000);
    check("R1 reset enable", {15'd0, timerWrEnable}, 16'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R6: set attempt right after reset is ignored, other fields land
    step("R1", 1'b1, CFGA, 16'h2005, 1'b1);
    check("R6 fields stored, enable held", cfgValue, 16'h0005);

    // R2: unlock then set in the window
    step("R2 key1", 1'b1, KEYA, 16'h0055, 1'b0);
    step("R2 key2", 1'b1, KEYA, 16'h00AA, 1'b0);
    step("R2 set", 1'b1, CFGA, 16'h2001, 1'b1);
    check("R2 enable set", cfgValue, 16'h2001);
    idle("R8 gate open");

    // R7: clear without keys
    step("R7 clear", 1'b1, CFGA, 16'h0102, 1'b1);
    check("R7 cleared", cfgValue, 16'h0102);

    // R3: one cycle late
    step("R3 key1", 1'b1, KEYA, 16'h0055, 1'b0);
    step("R3 key2", 1'b1, KEYA, 16'h00AA, 1'b0);
    idle("R3 gap");
    step("R3 late set", 1'b1, CFGA, 16'h2000, 1'b0);
    check("R3 late set ignored", {15'd0, timerWrEnable}, 16'h0);

    // R4: wrong second key, then foreign write between keys
    step("R4 key1", 1'b1, KEYA, 16'h0055, 1'b0);
    step("R4 bad", 1'b1, KEYA, 16'h005A, 1'b0);
    step("R4 key2", 1'b1, KEYA, 16'h00AA, 1'b0);
    step("R4 set", 1'b1, CFGA, 16'h2000, 1'b0);
    check("R4 bad key blocks", {15'd0, timerWrEnable}, 16'h0);
    step("R4 key1b", 1'b1, KEYA, 16'h0055, 1'b0);
    step("R4 other", 1'b1, OTHA, 16'h0055, 1'b0);
    step("R4 key2b", 1'b1, KEYA, 16'h00AA, 1'b0);
    step("R4 setb", 1'b1, CFGA, 16'h2000, 1'b0);
    check("R4 foreign write blocks", {15'd0, timerWrEnable}, 16'h0);
    // R4: repeated first key restarts
    step("R4 r1", 1'b1, KEYA, 16'h0055, 1'b0);
    step("R4 r2", 1'b1, KEYA, 16'h0055, 1'b0);
    step("R4 r3", 1'b1, KEYA, 16'h00AA, 1'b0);
    step("R4 rset", 1'b1, CFGA, 16'h2000, 1'b0);
    check("R4 restart unlocks", {15'd0, timerWrEnable}, 16'h1);
    step("R7 clear2", 1'b1, CFGA, 16'h0000, 1'b0);

    // R5: idle cycles between keys
    step("R5 key1", 1'b1, KEYA, 16'h0055, 1'b0);
    idle("R5 gap1");
    idle("R5 gap2");
    step("R5 key2", 1'b1, KEYA, 16'h00AA, 1'b0);
    step("R5 set", 1'b1, CFGA, 16'h2000, 1'b0);
    check("R5 gaps tolerated", {15'd0, timerWrEnable}, 16'h1);
    step("R7 clear3", 1'b1, CFGA, 16'h0000, 1'b0);

    // R9: upper data bits ignored in key compare
    step("R9 key1", 1'b1, KEYA, 16'h1255, 1'b0);
    step("R9 key2", 1'b1, KEYA, 16'hFFAA, 1'b0);
    step("R9 set", 1'b1, CFGA, 16'hA000, 1'b1);
    check("R9 upper bits ignored", cfgValue, 16'hA000);

    // random mix (R2 R3 R4 R6 R7 R8)
    for (int i = 0; i < 3000; i++) begin
      int pick;
      logic [15:0] d;
      pick = int'($urandom_range(99));
      d = 16'($urandom);
      if (pick < 30)      step("rand R4 key1", 1'b1, KEYA, {d[15:8], 8'h55}, d[0]);
      else if (pick < 55) step("rand R2 key2", 1'b1, KEYA, {d[15:8], 8'hAA}, d[0]);
      else if (pick < 75) step("rand R6 cfg", 1'b1, CFGA, d, d[1]);
      else if (pick < 85) step("rand R4 other", 1'b1, OTHA, d, d[0]);
      else if (pick < 90) step("rand R4 keyx", 1'b1, KEYA, d, d[0]);
      else                step("rand R5 idle", 1'b0, KEYA, d, d[0]);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule